// File: doc/BRIEF.md
# USB Endpoint Packet FIFO

This block is a byte buffer for one direction of one USB endpoint. It sits between the USB packet engine and the CPU. The writing side pushes bytes and ends each packet with a commit strobe if the packet was good, or an abort strobe if it was bad. The reading side takes bytes of the oldest committed packet. It ends that packet with an acknowledge strobe if the transfer succeeded, or a retry strobe if it failed. The FIFO records the length of every committed packet, so the reader always knows how many bytes the head packet holds.

The holding capacity follows from the configured maximum packet size. If that size fits twice into the buffer, the FIFO keeps two packets at once, so back-to-back transfers can be carried. If it does not fit twice, only one packet is kept. The control endpoint is always limited to one packet. The block reports isochronous overrun when a packet is committed with no free slot. It reports underrun when a packet must be sent and none is loaded.

Top module: `ep_pkt_fifo`

## Requirements
- R1: `dual_mode` is 1 exactly when `cfg_ctrl` is 0 and `cfg_maxp` is at most DEPTH/2 (32 bytes at the default DEPTH of 64); otherwise it is 0.
- R2: In single mode (`dual_mode`=0), `pkt_count` never exceeds 1, and bytes written while a packet is held are dropped.
- R3: In dual mode (`dual_mode`=1), two committed packets can be held together, and `pkt_count` (binary) reaches 2.
- R4: With `cfg_ctrl`=1, a second commit while one packet is held reports overrun, and the held packet is read back intact.
- R5: `pkt_ready` is 1 whenever `pkt_count` is nonzero. `pkt_bytes` then gives the byte count of the oldest committed packet.
- R6: `rd_byte` shows the byte at the read position. Each `rd_valid` cycle advances one byte, and bytes come out in the order they were written.
- R7: `wr_abort` rewinds the write position to the start of the open packet. Its bytes are never read, and an already committed packet is left unchanged.
- R8: `rd_retry` returns the read position to the first byte of the head packet, and the packet stays held.
- R9: `rd_ack` while a packet is held releases the oldest packet. The next packet then becomes the head, with its own length on `pkt_bytes`.
- R10: A `wr_commit` (without `wr_abort`) while all slots are full makes `overrun` 1 for the single following cycle. The packet is dropped and `pkt_count` is unchanged.
- R11: A `tx_req` while `pkt_count` is 0 makes `underrun` 1 for the single following cycle.
- R12: Bytes written after the open packet already holds `cfg_maxp` bytes are ignored, so a committed length never exceeds `cfg_maxp`.
- R13: In dual mode with one packet held, a commit and an acknowledge in the same cycle leave `pkt_count` unchanged. The new packet becomes the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_maxp | input | AW+1 | Maximum packet size in bytes (at most DEPTH) |
| cfg_ctrl | input | 1 | 1 for the control endpoint, which forces single mode |
| wr_valid | input | 1 | Write one byte this cycle |
| wr_byte | input | 8 | Byte to write |
| wr_commit | input | 1 | Open packet was good; commit it |
| wr_abort | input | 1 | Open packet was bad; rewind and discard it |
| rd_valid | input | 1 | Consume one byte this cycle |
| rd_byte | output | 8 | Byte at the read position |
| rd_ack | input | 1 | Head packet was sent; release it |
| rd_retry | input | 1 | Head packet failed; rewind to its start |
| tx_req | input | 1 | A packet must be sent now |
| pkt_ready | output | 1 | At least one committed packet is held |
| pkt_bytes | output | AW+1 | Length of the head packet |
| pkt_count | output | 2 | Number of committed packets held |
| dual_mode | output | 1 | 1 when two packets may be held |
| overrun | output | 1 | One-cycle pulse: commit with no free slot |
| underrun | output | 1 | One-cycle pulse: send request with nothing loaded |

## Verification
A commit on the write side and an acknowledge on the read side can land in the same cycle. The packet count must then stay put, while the slot pointers advance so that the newly committed packet becomes the head. The bench holds one packet in dual mode, finishes a second packet, and raises `wr_commit` and `rd_ack` together. It then judges `pkt_count`, `pkt_bytes` and the first byte shown on `rd_byte` one cycle later. A commit that meets full slots is the other collision: the overrun pulse must appear while the held packet stays readable.

// File: rtl/ep_pkt_fifo_pkg.sv
package ep_pkt_fifo_pkg;

  // two-packet mode when a max-size packet fits twice and the endpoint is not control
  function automatic logic pick_dual(input int unsigned maxp, input int unsigned depth,
                                     input logic ctrl);
    return !ctrl && (maxp <= depth / 2);
  endfunction

  function automatic logic [1:0] slot_cap(input logic dual);
    return dual ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] count_step(input logic [1:0] cnt, input logic inc,
                                            input logic dec);
    return cnt + {1'b0, inc} - {1'b0, dec};
  endfunction

endpackage

// File: rtl/ep_fifo_ram.sv
module ep_fifo_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep_fifo_wr_ctl.sv
module ep_fifo_wr_ctl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] maxp,
  input  logic          full,
  input  logic          wr_valid,
  input  logic          wr_commit,
  input  logic          wr_abort,
  output logic [AW-1:0] wr_ptr,
  output logic          accept,
  output logic          commit_ok,
  output logic          overrun_evt,
  output logic [LW-1:0] len_next
);
  logic [AW-1:0] ptr_q, base_q;
  logic [LW-1:0] len_q;
  logic [AW-1:0] ptr_adv;

  assign accept      = wr_valid && !full && (len_q < maxp);
  assign len_next    = len_q + LW'(accept);
  assign ptr_adv     = ptr_q + AW'(accept);
  assign commit_ok   = wr_commit && !wr_abort && !full;
  assign overrun_evt = wr_commit && !wr_abort && full;
  assign wr_ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (wr_abort || overrun_evt) begin
      ptr_q <= base_q;
      len_q <= '0;
    end else if (commit_ok) begin
      ptr_q  <= ptr_adv;
      base_q <= ptr_adv;
      len_q  <= '0;
    end else if (accept) begin
      ptr_q <= ptr_adv;
      len_q <= len_next;
    end
  end
endmodule

// File: rtl/ep_fifo_rd_ctl.sv
module ep_fifo_rd_ctl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_pkt,
  input  logic [LW-1:0] head_len,
  input  logic          rd_valid,
  input  logic          rd_ack,
  input  logic          rd_retry,
  output logic [AW-1:0] rd_ptr,
  output logic          release_evt
);
  logic [AW-1:0] ptr_q, base_q;
  logic [LW-1:0] off_q;
  logic          take;

  assign take        = rd_valid && have_pkt && (off_q < head_len);
  assign release_evt = rd_ack && have_pkt && !rd_retry;
  assign rd_ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      off_q  <= '0;
    end else if (rd_retry) begin
      ptr_q <= base_q;
      off_q <= '0;
    end else if (release_evt) begin
      base_q <= base_q + head_len[AW-1:0];
      ptr_q  <= base_q + head_len[AW-1:0];
      off_q  <= '0;
    end else if (take) begin
      ptr_q <= ptr_q + 1'b1;
      off_q <= off_q + 1'b1;
    end
  end
endmodule

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo
  import ep_pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1,
  localparam int NSLOT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_maxp,
  input  logic          cfg_ctrl,
  input  logic          wr_valid,
  input  logic [7:0]    wr_byte,
  input  logic          wr_commit,
  input  logic          wr_abort,
  input  logic          rd_valid,
  output logic [7:0]    rd_byte,
  input  logic          rd_ack,
  input  logic          rd_retry,
  input  logic          tx_req,
  output logic          pkt_ready,
  output logic [LW-1:0] pkt_bytes,
  output logic [1:0]    pkt_count,
  output logic          dual_mode,
  output logic          overrun,
  output logic          underrun
);
  // named internal events, visible to the bound checker
  logic          wr_commit_ok;
  logic          rd_release;
  logic          ovr_evt;
  logic          und_evt;
  logic          wr_accept;
  logic          full;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] wr_len_next;
  logic [1:0]    cnt_q;
  logic          wr_slot_q, rd_slot_q;
  logic [LW-1:0] slot_len [NSLOT];
  logic          ovr_q, und_q;

  assign dual_mode = pick_dual(int'(cfg_maxp), DEPTH, cfg_ctrl);
  assign full      = (cnt_q >= slot_cap(dual_mode));
  assign und_evt   = tx_req && (cnt_q == 2'd0);

  ep_fifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .maxp(cfg_maxp), .full(full),
    .wr_valid(wr_valid), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .wr_ptr(wr_ptr), .accept(wr_accept), .commit_ok(wr_commit_ok),
    .overrun_evt(ovr_evt), .len_next(wr_len_next)
  );

  ep_fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .have_pkt(cnt_q != 2'd0),
    .head_len(slot_len[rd_slot_q]), .rd_valid(rd_valid), .rd_ack(rd_ack),
    .rd_retry(rd_retry), .rd_ptr(rd_ptr), .release_evt(rd_release)
  );

  ep_fifo_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .clk(clk), .we(wr_accept), .waddr(wr_ptr), .wdata(wr_byte),
    .raddr(rd_ptr), .rdata(rd_byte)
  );

  // one length register per packet slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slot_len[s] <= '0;
      else if (wr_commit_ok && (wr_slot_q == 1'(s))) slot_len[s] <= wr_len_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      wr_slot_q <= 1'b0;
      rd_slot_q <= 1'b0;
      ovr_q     <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      cnt_q <= count_step(cnt_q, wr_commit_ok, rd_release);
      if (wr_commit_ok) wr_slot_q <= dual_mode ? ~wr_slot_q : 1'b0;
      if (rd_release)   rd_slot_q <= dual_mode ? ~rd_slot_q : 1'b0;
      ovr_q <= ovr_evt;
      und_q <= und_evt;
    end
  end

  assign pkt_count = cnt_q;
  assign pkt_ready = (cnt_q != 2'd0);
  assign pkt_bytes = slot_len[rd_slot_q];
  assign overrun   = ovr_q;
  assign underrun  = und_q;
endmodule

// File: rtl/ep_pkt_fifo_chk.sv
module ep_pkt_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ctrl,
  input logic       wr_commit,
  input logic       wr_abort,
  input logic       tx_req,
  input logic       pkt_ready,
  input logic [1:0] pkt_count,
  input logic       dual_mode,
  input logic       overrun,
  input logic       underrun,
  input logic       wr_commit_ok,
  input logic       rd_release
);
  logic [1:0] cap;
  assign cap = dual_mode ? 2'd2 : 2'd1;

  a_r2_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> pkt_count <= 2'd1);

  a_r3_dual_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= 2'd2);

  a_r4_ctrl_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ctrl |-> pkt_count <= 2'd1);

  a_r5_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_ok |=> pkt_ready);

  a_r7_abort_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_abort && !rd_release) |=> pkt_count == $past(pkt_count));

  a_r10_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !wr_abort && pkt_count >= cap) |=> overrun);

  a_r10_overrun_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !wr_abort && pkt_count >= cap && !rd_release)
      |=> pkt_count == $past(pkt_count));

  a_r11_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && pkt_count == 2'd0) |=> underrun);

  a_r13_commit_and_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit_ok && rd_release) |=> pkt_count == $past(pkt_count));
endmodule

bind ep_pkt_fifo ep_pkt_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .wr_commit(wr_commit),
  .wr_abort(wr_abort), .tx_req(tx_req), .pkt_ready(pkt_ready),
  .pkt_count(pkt_count), .dual_mode(dual_mode), .overrun(overrun),
  .underrun(underrun), .wr_commit_ok(wr_commit_ok), .rd_release(rd_release)
);

// File: tb/ep_pkt_fifo_tb.sv
module ep_pkt_fifo_tb;
  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH) + 1;

  // mode table: [8:2] maxp, [1] ctrl, [0] expected dual
  localparam logic [8:0] MODE_TAB [0:6] = '{
    {7'd64, 1'b0, 1'b0}, {7'd33, 1'b0, 1'b0}, {7'd32, 1'b0, 1'b1},
    {7'd8,  1'b0, 1'b1}, {7'd8,  1'b1, 1'b0}, {7'd1,  1'b0, 1'b1},
    {7'd32, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] cfg_maxp = '0;
  logic          cfg_ctrl = 1'b0;
  logic          wr_valid = 1'b0, wr_commit = 1'b0, wr_abort = 1'b0;
  logic [7:0]    wr_byte = '0;
  logic          rd_valid = 1'b0, rd_ack = 1'b0, rd_retry = 1'b0, tx_req = 1'b0;
  logic [7:0]    rd_byte;
  logic          pkt_ready, dual_mode, overrun, underrun;
  logic [LW-1:0] pkt_bytes;
  logic [1:0]    pkt_count;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ep_pkt_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_maxp(cfg_maxp), .cfg_ctrl(cfg_ctrl),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_commit(wr_commit),
    .wr_abort(wr_abort), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .rd_ack(rd_ack), .rd_retry(rd_retry), .tx_req(tx_req),
    .pkt_ready(pkt_ready), .pkt_bytes(pkt_bytes), .pkt_count(pkt_count),
    .dual_mode(dual_mode), .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_pkt(input int n, input int first);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_byte  = 8'(first + i);
      tick();
    end
    wr_valid  = 1'b0;
    wr_commit = 1'b1;
    tick();
    wr_commit = 1'b0;
  endtask

  task automatic rd_chk(input int n, input int first, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, rd_byte, (first + i) & 8'hff);
      rd_valid = 1'b1;
      tick();
    end
    rd_valid = 1'b0;
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    tick();
    rd_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // reset state (R5, R10, R11)
    chk("R5 reset ready", pkt_ready, 0);
    chk("R5 reset count", pkt_count, 0);
    chk("R10 reset overrun", overrun, 0);
    chk("R11 reset underrun", underrun, 0);
    rst_n = 1'b1;
    tick();

    // R1 / R4: mode selection table
    for (int k = 0; k < 7; k++) begin
      cfg_maxp = LW'(MODE_TAB[k][8:2]);
      cfg_ctrl = MODE_TAB[k][1];
      #1;
      chk("R1 dual_mode", dual_mode, MODE_TAB[k][0]);
    end

    // single mode
    cfg_maxp = 40; cfg_ctrl = 1'b0;
    tick();
    wr_pkt(5, 8'h10);
    chk("R5 ready", pkt_ready, 1);
    chk("R5 bytes", pkt_bytes, 5);
    chk("R2 count one", pkt_count, 1);
    wr_pkt(3, 8'h70);
    chk("R10 overrun pulse", overrun, 1);
    chk("R2 count held", pkt_count, 1);
    tick();
    chk("R10 overrun one cycle", overrun, 0);
    rd_chk(5, 8'h10, "R6 order");
    rd_retry = 1'b1; tick(); rd_retry = 1'b0;
    chk("R8 rewind byte", rd_byte, 8'h10);
    chk("R8 packet kept", pkt_count, 1);
    ack();
    chk("R9 released", pkt_count, 0);
    chk("R5 not ready", pkt_ready, 0);

    // underrun
    tx_req = 1'b1; tick(); tx_req = 1'b0;
    chk("R11 underrun pulse", underrun, 1);
    tick();
    chk("R11 underrun one cycle", underrun, 0);

    // dual mode, abort between packets
    cfg_maxp = 8;
    tick();
    wr_pkt(4, 8'h20);
    for (int i = 0; i < 2; i++) begin
      wr_valid = 1'b1; wr_byte = 8'h90; tick();
    end
    wr_valid = 1'b0;
    wr_abort = 1'b1; tick(); wr_abort = 1'b0;
    chk("R7 committed count", pkt_count, 1);
    chk("R7 committed bytes", pkt_bytes, 4);
    wr_pkt(3, 8'h30);
    chk("R3 two held", pkt_count, 2);
    chk("R3 head bytes", pkt_bytes, 4);
    rd_chk(4, 8'h20, "R7 first intact");
    ack();
    chk("R9 next head bytes", pkt_bytes, 3);
    rd_chk(3, 8'h30, "R7 no aborted bytes");
    ack();
    chk("R9 drained", pkt_count, 0);

    // length cap
    wr_pkt(10, 8'h50);
    chk("R12 capped length", pkt_bytes, 8);
    rd_chk(8, 8'h50, "R12 data");
    ack();

    // commit and ack together
    wr_pkt(2, 8'h60);
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1'b1; wr_byte = 8'(8'h68 + i); tick();
    end
    wr_valid = 1'b0;
    wr_commit = 1'b1; rd_ack = 1'b1; tick();
    wr_commit = 1'b0; rd_ack = 1'b0;
    chk("R13 count same", pkt_count, 1);
    chk("R13 new head bytes", pkt_bytes, 3);
    chk("R13 new head data", rd_byte, 8'h68);
    ack();

    // control endpoint holds one packet only
    cfg_ctrl = 1'b1;
    tick();
    wr_pkt(2, 8'h01);
    wr_pkt(2, 8'h05);
    chk("R4 overrun", overrun, 1);
    chk("R4 count", pkt_count, 1);
    rd_chk(2, 8'h01, "R4 data intact");
    ack();
    chk("R4 drained", pkt_count, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule